// File: doc/BRIEF.md
# Partitioned Secure RAM Access Controller

This block guards a secure on-chip RAM split into equal pages, each page being one partition. Every partition holds two tags: the domain ID that owns it and the security attribute (secure or non-secure) a requester must carry. Each access arrives with the requester's domain ID and attribute. The block forwards it to the RAM only when both match the tags of the partition the address falls in. Otherwise it answers with an error.

Only a manager identity may rewrite partition tags. The manager is a fixed domain ID presented with the secure attribute. When the security-violation input fires, the block takes over the RAM port and writes zero to every word in ascending order. It reports progress on busy and done outputs.

The RAM macro sits outside. The block drives its enable, write-enable, address and write-data pins. It expects read data one cycle after a read enable.

Top module: `sram_part_guard`

## Requirements
- R1: After reset every partition is owned by domain 0 with the secure attribute required, zero_busy and zero_done are 0, and rsp_valid and cfg_err are 0.
- R2: The partition of an access is the upper log2(PARTS) bits of req_addr (word address / PAGE_WORDS). A granted read returns the RAM word with rsp_err 0 in the cycle after the request.
- R3: An access whose req_did differs from the partition's owner is denied. rsp_err is 1 and rsp_rdata is 0.
- R4: An access whose req_secure differs from the partition's required attribute is denied, in both directions (secure requester on a non-secure partition and the reverse).
- R5: A denied write causes no RAM write, so the stored word is unchanged.
- R6: A tag update (cfg_valid) takes effect only when cfg_by_did equals MGR_DID and cfg_by_sec is 1. Any other source leaves the tags unchanged and raises cfg_err for one cycle, in the cycle after the attempt.
- R7: A violation seen while idle starts zeroization in the next cycle. Every RAM word gets zero written to it, one per cycle, from address 0 upward, for PARTS*PAGE_WORDS cycles, with zero_busy high throughout.
- R8: While zeroization runs, every access is denied with rsp_err 1 and zero data, and has no effect on the RAM.
- R9: zero_done rises when the last word is written and clears when a new zeroization starts. A violation during a running zeroization neither restarts nor lengthens it.
- R10: Every request gets exactly one response (rsp_valid) one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DATA_W | Write data |
| req_did | input | DID_W | Requester domain ID |
| req_secure | input | 1 | Requester attribute, 1 = secure |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access denied |
| rsp_rdata | output | DATA_W | Read data, zero unless a granted read |
| cfg_valid | input | 1 | Tag update request |
| cfg_part | input | PW | Partition to retag |
| cfg_owner | input | DID_W | New owner domain ID |
| cfg_secure | input | 1 | New required attribute |
| cfg_by_did | input | DID_W | Domain ID of the updating agent |
| cfg_by_sec | input | 1 | Attribute of the updating agent |
| cfg_err | output | 1 | Tag update rejected |
| violation | input | 1 | Security violation event |
| zero_busy | output | 1 | Zeroization in progress |
| zero_done | output | 1 | Zeroization completed |
| ram_en | output | 1 | RAM enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, one cycle latency |

## Verification
The access check is tried with four requester patterns against the same partition: a full match, a wrong domain with the right attribute, the right domain with the wrong attribute, and, after retagging, a secure requester on a non-secure partition. Together they separate a check that compares only one tag from one that compares both. Denied writes are followed by a granted read of the same word, which shows whether a denial still reached the RAM. Tag updates come from both a foreign agent and the manager, and the results are judged through later accesses. Zeroization is observed on the RAM port for order, data and length, with accesses issued during it and a second violation pulsed midway.

// File: rtl/sram_part_guard.sv
module sram_part_guard #(
  parameter int PARTS      = 16,
  parameter int PAGE_WORDS = 1024,
  parameter int DATA_W     = 32,
  parameter int DID_W      = 4,
  parameter logic [DID_W-1:0] MGR_DID = '1,
  localparam int DEPTH = PARTS * PAGE_WORDS,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = $clog2(PARTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DID_W-1:0]  req_did,
  input  logic              req_secure,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cfg_valid,
  input  logic [PW-1:0]     cfg_part,
  input  logic [DID_W-1:0]  cfg_owner,
  input  logic              cfg_secure,
  input  logic [DID_W-1:0]  cfg_by_did,
  input  logic              cfg_by_sec,
  output logic              cfg_err,
  input  logic              violation,
  output logic              zero_busy,
  output logic              zero_done,
  output logic              ram_en,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);

  logic [DID_W-1:0] tag_did [PARTS];
  logic [PARTS-1:0] tag_sec;
  logic [AW-1:0]    zaddr;
  logic             rd_ok;

  wire [PW-1:0] part   = req_addr[AW-1 -: PW];
  wire          match  = (tag_did[part] == req_did) && (tag_sec[part] == req_secure);
  wire          grant  = req_valid && !zero_busy && match;
  wire          cfg_ok = (cfg_by_did == MGR_DID) && cfg_by_sec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < PARTS; i++) tag_did[i] <= '0;
      tag_sec <= '1;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= cfg_valid && !cfg_ok;
      if (cfg_valid && cfg_ok) begin
        tag_did[cfg_part] <= cfg_owner;
        tag_sec[cfg_part] <= cfg_secure;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      zero_busy <= 1'b0;
      zero_done <= 1'b0;
      zaddr     <= '0;
    end else if (!zero_busy && violation) begin
      zero_busy <= 1'b1;
      zero_done <= 1'b0;
      zaddr     <= '0;
    end else if (zero_busy) begin
      zaddr <= zaddr + 1'b1;
      if (zaddr == AW'(DEPTH - 1)) begin
        zero_busy <= 1'b0;
        zero_done <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rd_ok     <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !grant;
      rd_ok     <= grant && !req_write;
    end

  assign rsp_rdata = rd_ok ? ram_rdata : '0;
  assign ram_en    = zero_busy || grant;
  assign ram_we    = zero_busy || (grant && req_write);
  assign ram_addr  = zero_busy ? zaddr : req_addr;
  assign ram_wdata = zero_busy ? '0 : req_wdata;

endmodule

// File: rtl/sram_part_guard_chk.sv
module sram_part_guard_chk #(
  parameter int DATA_W = 32,
  parameter int AW     = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              violation,
  input logic              zero_busy,
  input logic              zero_done,
  input logic              ram_en,
  input logic              ram_we,
  input logic [DATA_W-1:0] ram_wdata
);

  a_r3_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == '0);

  a_r5_denied_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err && !$past(zero_busy)) |-> !$past(ram_en));

  a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
    (violation && !zero_busy) |=> zero_busy);

  a_r7_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    zero_busy |-> (ram_en && ram_we && ram_wdata == '0));

  a_r8_busy_denies: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_busy && req_valid) |=> rsp_err);

  a_r9_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    zero_done |-> !zero_busy);

  a_r10_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

endmodule

bind sram_part_guard sram_part_guard_chk #(.DATA_W(DATA_W), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .violation(violation),
  .zero_busy(zero_busy), .zero_done(zero_done), .ram_en(ram_en),
  .ram_we(ram_we), .ram_wdata(ram_wdata)
);

// File: tb/sram_part_guard_test.sv
module sram_part_guard_test;
  localparam int PARTS = 16, PAGE_WORDS = 16, DATA_W = 32, DID_W = 4;
  localparam int DEPTH = PARTS * PAGE_WORDS;
  localparam int AW = $clog2(DEPTH), PW = $clog2(PARTS);
  localparam logic [DID_W-1:0] MGR = 4'hF;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_secure = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [DID_W-1:0] req_did = '0;
  logic rsp_valid, rsp_err, cfg_err, zero_busy, zero_done;
  logic [DATA_W-1:0] rsp_rdata;
  logic cfg_valid = 0, cfg_secure = 0, cfg_by_sec = 0, violation = 0;
  logic [PW-1:0] cfg_part = '0;
  logic [DID_W-1:0] cfg_owner = '0, cfg_by_did = '0;
  logic ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;
  logic [DATA_W-1:0] mem [DEPTH];

  int tests = 0, fails = 0;
  int zcount = 0, zbad = 0, zexp = 0;

  always #5 clk = ~clk;

  sram_part_guard #(.PARTS(PARTS), .PAGE_WORDS(PAGE_WORDS), .DATA_W(DATA_W),
                    .DID_W(DID_W), .MGR_DID(MGR)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_did(req_did),
    .req_secure(req_secure), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .cfg_valid(cfg_valid), .cfg_part(cfg_part),
    .cfg_owner(cfg_owner), .cfg_secure(cfg_secure), .cfg_by_did(cfg_by_did),
    .cfg_by_sec(cfg_by_sec), .cfg_err(cfg_err), .violation(violation),
    .zero_busy(zero_busy), .zero_done(zero_done), .ram_en(ram_en),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata));

  initial for (int i = 0; i < DEPTH; i++) mem[i] = 32'hC0DE_0000 + i;

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else ram_rdata <= mem[ram_addr];
    end
    if (zero_busy && ram_en && ram_we) begin
      if (ram_wdata != 0 || int'(ram_addr) != zexp) zbad++;
      zexp++;
      zcount++;
    end
  end

  initial begin
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int addr, input logic [31:0] wd,
                        input int did, input bit sec, input bit exp_err,
                        input logic [31:0] exp_rd, input string req);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(addr); req_wdata = wd;
    req_did = DID_W'(did); req_secure = sec;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid == 1, {req, " valid"}, rsp_valid, 1);
    check(rsp_err == exp_err, {req, " err"}, rsp_err, exp_err);
    if (!wr) check(rsp_rdata == exp_rd, {req, " data"}, rsp_rdata, exp_rd);
  endtask

  task automatic retag(input int p, input int owner, input bit sec,
                       input int by, input bit bysec, input bit exp_err);
    @(negedge clk);
    cfg_valid = 1; cfg_part = PW'(p); cfg_owner = DID_W'(owner);
    cfg_secure = sec; cfg_by_did = DID_W'(by); cfg_by_sec = bysec;
    @(negedge clk);
    cfg_valid = 0;
    check(cfg_err == exp_err, "R6 cfg_err", cfg_err, exp_err);
    @(negedge clk);
    check(cfg_err == 0, "R6 cfg_err one cycle", cfg_err, 0);
  endtask

  task automatic test_reset();
    check(rsp_valid == 0 && cfg_err == 0, "R1 outputs idle", {rsp_valid, cfg_err}, 0);
    check(zero_busy == 0 && zero_done == 0, "R1 zero status", {zero_busy, zero_done}, 0);
    access(0, 200, 0, 0, 1, 0, 32'hC0DE_0000 + 200, "R1 default tag domain0 secure");
  endtask

  task automatic test_grant();
    access(1, 5, 32'hA5A5_0005, 0, 1, 0, 0, "R2 write");
    access(0, 5, 0, 0, 1, 0, 32'hA5A5_0005, "R2 read back");
    access(0, 17, 0, 0, 1, 0, 32'hC0DE_0000 + 17, "R2 second partition");
  endtask

  task automatic test_deny();
    access(0, 5, 0, 1, 1, 1, 0, "R3 wrong domain");
    access(0, 5, 0, 0, 0, 1, 0, "R4 nonsecure on secure partition");
    access(1, 5, 32'hDEAD_BEEF, 1, 1, 1, 0, "R5 denied write domain");
    access(1, 5, 32'hDEAD_BEEF, 0, 0, 1, 0, "R5 denied write attribute");
    access(0, 5, 0, 0, 1, 0, 32'hA5A5_0005, "R5 word unchanged");
  endtask

  task automatic test_cfg();
    retag(3, 2, 0, 2, 1, 1);
    access(0, 49, 0, 2, 0, 1, 0, "R6 foreign retag ignored (new owner denied)");
    access(0, 49, 0, 0, 1, 0, 32'hC0DE_0000 + 49, "R6 foreign retag ignored (old owner ok)");
    retag(3, 2, 0, MGR, 0, 1);
    retag(3, 2, 0, MGR, 1, 0);
    access(1, 49, 32'h1234_5678, 2, 0, 0, 0, "R6 new owner write");
    access(0, 49, 0, 2, 0, 0, 32'h1234_5678, "R6 new owner read");
    access(0, 49, 0, 2, 1, 1, 0, "R4 secure on nonsecure partition");
    access(0, 49, 0, 0, 1, 1, 0, "R3 old owner denied");
  endtask

  task automatic test_zeroize(input bit repulse);
    int cyc = 0;
    zcount = 0; zbad = 0; zexp = 0;
    @(negedge clk);
    violation = 1;
    @(negedge clk);
    violation = 0;
    check(zero_busy == 1, "R7 busy next cycle", zero_busy, 1);
    check(zero_done == 0, "R9 done cleared on start", zero_done, 0);
    while (zero_busy && cyc < 10000) begin
      cyc++;
      if (cyc == 5) begin
        req_valid = 1; req_write = 1; req_addr = 7; req_wdata = 32'hFFFF_FFFF;
        req_did = 0; req_secure = 1;
      end else if (cyc == 6) begin
        req_valid = 0;
        check(rsp_err == 1 && rsp_rdata == 0, "R8 denied while busy", rsp_err, 1);
      end
      if (repulse && cyc == 20) violation = 1;
      if (repulse && cyc == 21) violation = 0;
      @(negedge clk);
    end
    req_valid = 0; violation = 0;
    check(cyc == DEPTH, repulse ? "R9 no restart length" : "R7 length", cyc, DEPTH);
    check(zcount == DEPTH && zbad == 0, "R7 ascending zero writes", zcount, DEPTH);
    check(zero_done == 1, "R9 done set", zero_done, 1);
    access(0, 5, 0, 0, 1, 0, 0, "R7 partition 0 word cleared");
    access(0, 49, 0, 2, 0, 0, 0, "R7 partition 3 word cleared");
    access(0, 7, 0, 0, 1, 0, 0, "R8 busy write had no effect");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_grant();
    test_deny();
    test_cfg();
    test_zeroize(0);
    test_zeroize(1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule